// File: doc/BRIEF.md
# Multiplexed-Bus I/O Port Pair

This block gives a processor with a shared address/data bus two fixed I/O port numbers. Together they form an even/odd pair. Each port has an 8-bit output register that drives indicator lamps and an 8-bit switch input that can be read back. In the address phase, while the latch-enable strobe is high, the block captures the port number from the low bus lines. The block keeps that number, together with a transfer-width flag, for the rest of the bus cycle.

A write to a selected port is committed at the low-to-high transition of the active-low write strobe. The byte committed is the one present on the bus while the strobe was low. The output register then holds that byte until the next write to the same port. A read to a selected port enables the switch bytes onto the bus only while the active-low read strobe is low. At every other time both byte lanes are released.

A wide (16-bit) transfer addressed to the even port moves both bytes in one cycle. The low byte goes to the even port and the high byte to the odd port. An 8-bit bus reaches the same two registers with two byte cycles, one to each port number. All strobes are sampled on the system clock.

Top module: `io_port_pair`

## Requirements
- R1: While rst_ni is low, and after its release, both output registers are 0x00 and ad_oe_o is 2'b00. No read drives the bus until an address has been captured with ale_i.
- R2: On every clock edge with ale_i high, the port number is taken from ad_i[7:0] and the width flag from wide_i. Both are held while ale_i is low, even though ad_i then carries data.
- R3: The output registers change only at a clock edge where wr_ni is sampled high after being sampled low on the previous edge. At all other times they hold their value.
- R4: The byte committed is the one on ad_i at the last clock edge at which wr_ni was sampled low. Values on ad_i after the strobe rises have no effect.
- R5: ad_oe_o is non-zero only while rd_ni is low, ale_i is low and the captured address selects the block. At all other times both lanes are released.
- R6: A byte cycle (wide flag 0) at PAIR_BASE (default 0x40, must be even) writes ad_i[7:0] into led_lo_o. A read at that address drives sw_lo_i on ad_o[7:0] with ad_oe_o = 2'b01.
- R7: A byte cycle at PAIR_BASE+1 writes ad_i[7:0] into led_hi_o. A read at that address drives sw_hi_i on ad_o[7:0] with ad_oe_o = 2'b01.
- R8: A wide cycle at PAIR_BASE writes ad_i[7:0] to led_lo_o and ad_i[15:8] to led_hi_o in a single strobe. A wide read there drives {sw_hi_i, sw_lo_i} on ad_o with ad_oe_o = 2'b11. ad_oe_o[1] is never set without ad_oe_o[0].
- R9: Any other port number, and a wide cycle at PAIR_BASE+1, neither writes a register nor drives the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ale_i | input | 1 | Address latch enable, high in the address phase |
| wide_i | input | 1 | 16-bit transfer flag, sampled with ale_i |
| ad_i | input | 16 | Multiplexed address/data lines as seen by the block |
| wr_ni | input | 1 | I/O write strobe, active low |
| rd_ni | input | 1 | I/O read strobe, active low |
| sw_lo_i | input | 8 | Switch inputs for the even port |
| sw_hi_i | input | 8 | Switch inputs for the odd port |
| ad_o | output | 16 | Read data toward the bus |
| ad_oe_o | output | 2 | Per-lane bus drive enable (bit 0 low byte, bit 1 high byte) |
| led_lo_o | output | 8 | Output register of the even port |
| led_hi_o | output | 8 | Output register of the odd port |

## Verification
The hardest situation to reach is a write in which the bus lines change meaning inside one cycle. The address has to survive while the same lines carry data. The data also keeps changing while the strobe is low, and again after the strobe rises. The stimulus deliberately puts a second port number's value on the data lines, changes the data on every strobe-low clock, and places junk on the bus the moment the strobe rises. This shows that only the latched address and the last strobe-low byte matter. Wide cycles at the odd port, and reads issued before any address has been captured, check the cases where the block must stay silent. A long run of mixed random cycles is compared with a behavioural model on every clock.

// File: rtl/io_pair_pkg.sv
package io_pair_pkg;
  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_LO   = 2'd1,
    HIT_HI   = 2'd2,
    HIT_BOTH = 2'd3
  } hit_e;
endpackage

// File: rtl/iop_addr_latch.sv
module iop_addr_latch
  import io_pair_pkg::*;
#(
  parameter int unsigned          ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]    PAIR_BASE = 'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ale_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  output hit_e              hit_o
);
  localparam logic [ADDR_W-1:0] HI_PORT = PAIR_BASE + 1'b1;

  logic [ADDR_W-1:0] addr_q;
  logic              wide_q;
  logic              vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      wide_q <= 1'b0;
      vld_q  <= 1'b0;
    end else if (ale_i) begin
      addr_q <= addr_i;
      wide_q <= wide_i;
      vld_q  <= 1'b1;
    end
  end

  always_comb begin
    hit_o = HIT_NONE;
    if (vld_q) begin
      if (wide_q) begin
        if (addr_q == PAIR_BASE) hit_o = HIT_BOTH;
      end else if (addr_q == PAIR_BASE) begin
        hit_o = HIT_LO;
      end else if (addr_q == HI_PORT) begin
        hit_o = HIT_HI;
      end
    end
  end

  // R2: address survives the data phase
  a_r2_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ale_i |=> ($stable(addr_q) && $stable(wide_q)));
endmodule

// File: rtl/iop_wr_capture.sv
module iop_wr_capture
  import io_pair_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_ni,
  input  logic [2*DATA_W-1:0] data_i,
  input  hit_e                hit_i,
  output logic [DATA_W-1:0]   lo_o,
  output logic [DATA_W-1:0]   hi_o
);
  logic                wr_q;
  logic [2*DATA_W-1:0] data_q;
  logic                commit;

  // strobe rising edge seen on the clock
  assign commit = !wr_q && wr_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b1;
      data_q <= '0;
    end else begin
      wr_q <= wr_ni;
      if (!wr_ni) data_q <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_o <= '0;
      hi_o <= '0;
    end else if (commit) begin
      unique case (hit_i)
        HIT_LO:   lo_o <= data_q[DATA_W-1:0];
        HIT_HI:   hi_o <= data_q[DATA_W-1:0];
        HIT_BOTH: begin
          lo_o <= data_q[DATA_W-1:0];
          hi_o <= data_q[2*DATA_W-1:DATA_W];
        end
        default: ;
      endcase
    end
  end

  // R3: no strobe edge, no change
  a_r3_hold_without_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(wr_ni) |=> ($stable(lo_o) && $stable(hi_o)));
endmodule

// File: rtl/iop_rd_drive.sv
module iop_rd_drive
  import io_pair_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                rd_ni,
  input  logic                ale_i,
  input  hit_e                hit_i,
  input  logic [DATA_W-1:0]   sw_lo_i,
  input  logic [DATA_W-1:0]   sw_hi_i,
  output logic [2*DATA_W-1:0] data_o,
  output logic [1:0]          oe_o
);
  logic active;
  assign active = !rd_ni && !ale_i;

  always_comb begin
    data_o = '0;
    oe_o   = 2'b00;
    if (active) begin
      unique case (hit_i)
        HIT_LO:   begin data_o[DATA_W-1:0] = sw_lo_i; oe_o = 2'b01; end
        HIT_HI:   begin data_o[DATA_W-1:0] = sw_hi_i; oe_o = 2'b01; end
        HIT_BOTH: begin data_o = {sw_hi_i, sw_lo_i};  oe_o = 2'b11; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/io_port_pair.sv
module io_port_pair
  import io_pair_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 8,
  parameter int unsigned       DATA_W    = 8,
  parameter logic [ADDR_W-1:0] PAIR_BASE = 'h40
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ale_i,
  input  logic                wide_i,
  input  logic [2*DATA_W-1:0] ad_i,
  input  logic                wr_ni,
  input  logic                rd_ni,
  input  logic [DATA_W-1:0]   sw_lo_i,
  input  logic [DATA_W-1:0]   sw_hi_i,
  output logic [2*DATA_W-1:0] ad_o,
  output logic [1:0]          ad_oe_o,
  output logic [DATA_W-1:0]   led_lo_o,
  output logic [DATA_W-1:0]   led_hi_o
);
  hit_e hit;

  iop_addr_latch #(.ADDR_W(ADDR_W), .PAIR_BASE(PAIR_BASE)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ale_i  (ale_i),
    .wide_i (wide_i),
    .addr_i (ad_i[ADDR_W-1:0]),
    .hit_o  (hit)
  );

  iop_wr_capture #(.DATA_W(DATA_W)) u_wr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_ni  (wr_ni),
    .data_i (ad_i),
    .hit_i  (hit),
    .lo_o   (led_lo_o),
    .hi_o   (led_hi_o)
  );

  iop_rd_drive #(.DATA_W(DATA_W)) u_rd (
    .rd_ni   (rd_ni),
    .ale_i   (ale_i),
    .hit_i   (hit),
    .sw_lo_i (sw_lo_i),
    .sw_hi_i (sw_hi_i),
    .data_o  (ad_o),
    .oe_o    (ad_oe_o)
  );

  // R5: bus driven only inside a read strobe, outside the address phase
  a_r5_drive_needs_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ad_oe_o) |-> (!rd_ni && !ale_i));

  // R8: upper lane only together with lower lane
  a_r8_upper_lane_pairs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o[1] |-> ad_oe_o[0]);
endmodule

// File: tb/io_port_pair_tb.sv
`timescale 1ns/1ps
module io_port_pair_tb;
  localparam logic [7:0] BASE = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ale = 1'b0, wide = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
  logic [15:0] ad = 16'h0;
  logic [7:0]  sw_lo = 8'hA5, sw_hi = 8'h3C;
  logic [15:0] ad_o;
  logic [1:0]  ad_oe;
  logic [7:0]  led_lo, led_hi;

  int vectors = 0;
  int fails   = 0;

  always #2.5 clk = ~clk;

  io_port_pair u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ale_i(ale), .wide_i(wide), .ad_i(ad),
    .wr_ni(wr_n), .rd_ni(rd_n), .sw_lo_i(sw_lo), .sw_hi_i(sw_hi),
    .ad_o(ad_o), .ad_oe_o(ad_oe), .led_lo_o(led_lo), .led_hi_o(led_hi)
  );

  // behavioural reference
  logic       m_vld, m_wide, m_wrq;
  logic [7:0] m_addr, m_lo, m_hi;
  logic [15:0] m_wd;

  function automatic int m_sel();
    if (!m_vld) return 0;
    if (m_wide) return (m_addr == BASE) ? 3 : 0;
    if (m_addr == BASE) return 1;
    if (m_addr == BASE + 8'd1) return 2;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vld <= 0; m_wide <= 0; m_wrq <= 1; m_addr <= 0;
      m_lo <= 0; m_hi <= 0; m_wd <= 0;
    end else begin
      if (ale) begin m_addr <= ad[7:0]; m_wide <= wide; m_vld <= 1; end
      if (!m_wrq && wr_n) begin
        case (m_sel())
          1: m_lo <= m_wd[7:0];
          2: m_hi <= m_wd[7:0];
          3: begin m_lo <= m_wd[7:0]; m_hi <= m_wd[15:8]; end
          default: ;
        endcase
      end
      if (!wr_n) m_wd <= ad;
      m_wrq <= wr_n;
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_now();
    logic [1:0]  e_oe;
    logic [15:0] e_d;
    int s;
    s = m_sel();
    e_oe = 2'b00; e_d = 16'h0;
    if (!rd_n && !ale) begin
      if (s == 1) begin e_oe = 2'b01; e_d = {8'h0, sw_lo}; end
      if (s == 2) begin e_oe = 2'b01; e_d = {8'h0, sw_hi}; end
      if (s == 3) begin e_oe = 2'b11; e_d = {sw_hi, sw_lo}; end
    end
    chk("R3 model led_lo", {8'h0, led_lo}, {8'h0, m_lo});
    chk("R3 model led_hi", {8'h0, led_hi}, {8'h0, m_hi});
    chk("R5 model ad_oe", {14'h0, ad_oe}, {14'h0, e_oe});
    if (e_oe[0]) chk("R5 model ad_o lo", {8'h0, ad_o[7:0]}, {8'h0, e_d[7:0]});
    if (e_oe[1]) chk("R5 model ad_o hi", {8'h0, ad_o[15:8]}, {8'h0, e_d[15:8]});
  endtask

  task automatic step(logic a, logic w, logic [15:0] d, logic wn, logic rn);
    @(negedge clk);
    compare_now();
    ale = a; wide = w; ad = d; wr_n = wn; rd_n = rn;
  endtask

  task automatic bus_write(logic [7:0] addr, logic w, logic [15:0] data);
    step(1, w, {8'h0, addr}, 1, 1);
    step(0, 0, data, 0, 1);
    step(0, 0, data, 0, 1);
    step(0, 0, data, 1, 1);
    step(0, 0, 16'hDEAD, 1, 1);
    step(0, 0, 16'hBEEF, 1, 1);
  endtask

  task automatic bus_read(string tag, logic [7:0] addr, logic w, logic [1:0] e_oe, logic [15:0] e_d);
    step(1, w, {8'h0, addr}, 1, 1);
    step(0, 0, 16'h5A5A, 1, 0);
    #1;
    chk({tag, " read oe"}, {14'h0, ad_oe}, {14'h0, e_oe});
    if (e_oe[0]) chk({tag, " read low lane"}, {8'h0, ad_o[7:0]}, {8'h0, e_d[7:0]});
    if (e_oe[1]) chk({tag, " read high lane"}, {8'h0, ad_o[15:8]}, {8'h0, e_d[15:8]});
    step(0, 0, 16'h5A5A, 1, 0);
    step(0, 0, 16'h1111, 1, 1);
    #1;
    chk("R5 released after read", {14'h0, ad_oe}, 16'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset led_lo", {8'h0, led_lo}, 16'h0);
    chk("R1 reset oe", {14'h0, ad_oe}, 16'h0);
    rst_n = 1'b1;
    // R1: read before any address captured
    step(0, 0, {8'h0, BASE}, 1, 0);
    #1 chk("R1 no drive before address", {14'h0, ad_oe}, 16'h0);
    step(0, 0, 16'h0, 1, 1);
    chk("R1 leds after reset", {led_hi, led_lo}, 16'h0);

    bus_write(BASE, 0, 16'h0076);
    chk("R6 byte write low port", {led_hi, led_lo}, 16'h0076);
    bus_write(BASE + 8'd1, 0, 16'h0098);
    chk("R7 byte write high port", {led_hi, led_lo}, 16'h9876);
    bus_write(BASE, 1, 16'h1234);
    chk("R8 wide write", {led_hi, led_lo}, 16'h1234);
    bus_write(8'h99, 0, 16'h00FF);
    chk("R9 other port ignored", {led_hi, led_lo}, 16'h1234);
    bus_write(BASE + 8'd1, 1, 16'hABCD);
    chk("R9 wide at odd port ignored", {led_hi, led_lo}, 16'h1234);
    // R2: data phase carries the odd port number
    bus_write(BASE, 0, 16'h0041);
    chk("R2 latched address kept", {led_hi, led_lo}, 16'h1241);

    // R4: data changes while strobe low, junk after the rise
    step(1, 0, {8'h0, BASE + 8'd1}, 1, 1);
    step(0, 0, 16'h0011, 0, 1);
    step(0, 0, 16'h0022, 0, 1);
    step(0, 0, 16'h0033, 0, 1);
    step(0, 0, 16'h0044, 1, 1);
    step(0, 0, 16'h0055, 1, 1);
    step(0, 0, 16'h0066, 1, 1);
    chk("R4 last strobe-low byte", {8'h0, led_hi}, 16'h0033);

    // R3: address phases and junk without a write strobe
    for (int i = 0; i < 10; i++) step(i[0], 0, {8'h0, BASE}, 1, 1);
    chk("R3 hold without strobe edge", {led_hi, led_lo}, 16'h3341);

    bus_read("R6", BASE, 0, 2'b01, {8'h0, sw_lo});
    bus_read("R7", BASE + 8'd1, 0, 2'b01, {8'h0, sw_hi});
    bus_read("R8", BASE, 1, 2'b11, {sw_hi, sw_lo});
    bus_read("R9", 8'h99, 0, 2'b00, 16'h0);
    bus_read("R9 wide odd", BASE + 8'd1, 1, 2'b00, 16'h0);
    // R5: read strobe during address phase
    step(1, 0, {8'h0, BASE}, 1, 0);
    #1 chk("R5 no drive while ale high", {14'h0, ad_oe}, 16'h0);
    step(0, 0, 16'h0, 1, 1);

    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      int pick;
      pick = $urandom_range(0, 3);
      a = (pick == 0) ? BASE : (pick == 1) ? BASE + 8'd1 : (pick == 2) ? 8'h99 : 8'($urandom);
      sw_lo = 8'($urandom); sw_hi = 8'($urandom);
      if ($urandom_range(0, 1) == 1) bus_write(a, 1'($urandom), 16'($urandom));
      else begin
        step(1, 1'($urandom), {8'h0, a}, 1, 1);
        step(0, 0, 16'($urandom), 1, 0);
        step(0, 0, 16'($urandom), 1, 0);
        step(0, 0, 16'($urandom), 1, 1);
      end
    end
    step(0, 0, 16'h0, 1, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule